// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A loadable root register gives the physical byte address of the top-level table. The virtual address is split into a 12-bit top index (bits 31:20), a 10-bit leaf index (bits 19:10) and a 10-bit offset within a 1 KB page (bits 9:0). The walker reads the top-level entry, follows its frame number to the leaf table, reads the leaf entry and forms the physical address from the leaf frame number and the unchanged offset.

At both levels the entry must be present and must grant the requested kind of access. Otherwise the walk ends with a fault code and no physical address. On a successful walk the leaf entry is marked as accessed, and as modified when the access is a store. If that changes the entry, the entry is written back with one memory write before completion is signalled. Only one walk runs at a time. Memory traffic uses one request port with a valid/ready handshake, and each read gets one response beat.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `fault`, `mem_req_valid` are 0 and `root_q` is 0.
- R2: A `root_we` pulse while `busy` is 0 loads `root_wdata` into `root_q` on the next clock edge. A `root_we` pulse while `busy` is 1 is ignored, and the walk in progress keeps using the old root.
- R3: `req_valid` is accepted only while `busy` is 0, and `busy` is 1 from the next cycle until the cycle in which `done` or `fault` pulses. A `req_valid` while busy is ignored: it produces no extra walk, no extra memory access and no extra completion.
- R4: The first memory read goes to `root_q + vaddr[31:20]*4`.
- R5: The second memory read goes to `{top_entry[31:10], 10'b0} + vaddr[19:10]*4`.
- R6: An entry is 32 bits: bit 0 present, bit 1 read-allowed, bit 2 write-allowed, bit 3 execute-allowed, bit 4 accessed, bit 5 modified, bits 31:10 frame number. When an entry at either level is not present, the walk pulses `fault` with `fault_code` = 2'b01 and issues no further memory access.
- R7: `req_acc` is 2'b00 for load, 2'b01 for store, 2'b10 for fetch, and 2'b11 is reserved. When a present entry at either level lacks the matching permission bit (for 2'b11 it always does), the walk pulses `fault` with `fault_code` = 2'b10 and issues no further memory access. A level that is not present reports 2'b01 regardless of its permission bits.
- R8: A successful walk pulses `done` for one cycle with `pa` = `{leaf_entry[31:10], vaddr[9:0]}`.
- R9: On success the leaf entry with bit 4 set, plus bit 5 set for a store, is written back to the leaf entry's address with exactly one write before `done`, and only if this differs from the value read. Otherwise no write is made.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request, its address and its direction stay unchanged on the next cycle.
- R11: `done` and `fault` are never 1 in the same cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_we | input | 1 | Load strobe for the root register |
| root_wdata | input | 32 | New root table byte address |
| root_q | output | 32 | Current root register value, for saving on a context switch |
| req_valid | input | 1 | Start a walk |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| busy | output | 1 | A walk is in progress; requests are not taken |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_code | output | 2 | 01 not present, 10 permission denied; valid with `fault` |
| pa | output | 32 | Physical address, valid with `done` |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 for the entry write-back, 0 for a read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_wdata | output | 32 | Updated entry for the write-back |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The bench sweeps every combination of top-level present and permission bits, leaf present and permission bits, access kind and prior accessed/modified state. The memory model's ready line stalls at random. A walker that checked permissions only at the leaf would issue a second read where a fault is due. One that tested permission before presence would report 2'b10 for absent entries. One that always wrote back, or never set the modified bit on a store, would show a wrong write count or wrong write data. The bench also loads the root register and raises a second request in the middle of a walk. A design that honoured either would read from the wrong table or produce a second completion.

// File: rtl/ptw_pkg.sv
// ptw_pkg: shared encodings for the two-level page table walker.
// Assumes a 32-bit entry whose flag bits sit in the low byte and whose
// frame number fills the bits above the page offset.
package ptw_pkg;

    // Access kind requested by the client
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;

    // Outcome code reported with a fault
    localparam logic [1:0] FLT_NONE    = 2'b00;
    localparam logic [1:0] FLT_ABSENT  = 2'b01;
    localparam logic [1:0] FLT_DENIED  = 2'b10;

    // Flag positions inside an entry
    localparam int unsigned E_PRESENT = 0;
    localparam int unsigned E_RD      = 1;
    localparam int unsigned E_WR      = 2;
    localparam int unsigned E_EX      = 3;
    localparam int unsigned E_TOUCHED = 4;
    localparam int unsigned E_MODIFIED = 5;

    // Walk sequencer states
    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_TOP_REQ = 3'd1,
        WS_TOP_RSP = 3'd2,
        WS_LEAF_REQ = 3'd3,
        WS_LEAF_RSP = 3'd4,
        WS_WB_REQ  = 3'd5
    } wstate_t;

endpackage

// File: rtl/ptw_root_reg.sv
// ptw_root_reg: holds the physical byte address of the top-level table.
// Software loads it through a write strobe; loads are refused while a walk
// is in progress so that a walk sees one consistent root.
module ptw_root_reg #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          hold,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] q
);

    // Root register: cleared by reset, loaded only when no walk is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en && !hold) begin
            q <= wdata;
        end
    end

    // R2: a load strobe during a walk leaves the root unchanged
    a_r2_root_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q));

endmodule

// File: rtl/ptw_entry_addr.sv
// ptw_entry_addr: byte address of a table entry from the table base and
// an index. Assumes entries of 2**ENT_LG bytes, laid out contiguously.
module ptw_entry_addr #(
    parameter int unsigned AW     = 32,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned ENT_LG = 2
) (
    input  logic [AW-1:0]    table_base,
    input  logic [IDX_W-1:0] index,
    output logic [AW-1:0]    entry_addr
);

    localparam int unsigned PAD_W = AW - IDX_W - ENT_LG;

    logic [AW-1:0] scaled;

    // Scale the index by the entry size and add it to the base
    always_comb begin
        scaled     = {{PAD_W{1'b0}}, index, {ENT_LG{1'b0}}};
        entry_addr = table_base + scaled;
    end

endmodule

// File: rtl/ptw_entry_check.sv
// ptw_entry_check: judges one entry against the requested access kind and
// forms the entry value a successful walk would store back.
// Assumes presence is judged before permission.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int unsigned EW = 32
) (
    input  logic [EW-1:0] entry,
    input  logic [1:0]    acc,
    output logic          pass,
    output logic [1:0]    code,
    output logic [EW-1:0] updated,
    output logic          changed
);

    logic          allowed;
    logic [EW-1:0] set_mask;

    // Pick the permission bit that matches the access kind
    always_comb begin
        unique case (acc)
            ACC_LOAD:  allowed = entry[E_RD];
            ACC_STORE: allowed = entry[E_WR];
            ACC_FETCH: allowed = entry[E_EX];
            default:   allowed = 1'b0;
        endcase
    end

    // Verdict: absence wins over a missing permission
    always_comb begin
        if (!entry[E_PRESENT]) begin
            code = FLT_ABSENT;
        end else if (!allowed) begin
            code = FLT_DENIED;
        end else begin
            code = FLT_NONE;
        end
        pass = (code == FLT_NONE);
    end

    // Updated entry: mark accessed, and modified on a store
    always_comb begin
        set_mask             = '0;
        set_mask[E_TOUCHED]  = 1'b1;
        set_mask[E_MODIFIED] = (acc == ACC_STORE);
        updated              = entry | set_mask;
        changed              = (updated != entry);
    end

    // R9: the update touches nothing but the two tracking flags
    always_comb begin
        a_r9_only_flags: assert (((updated ^ entry) &
            ~(EW'(1) << E_TOUCHED) & ~(EW'(1) << E_MODIFIED)) == '0);
    end

endmodule

// File: rtl/pt_walker.sv
// pt_walker: two-level page table walker with 1 KB pages.
// Splits the virtual address into top index, leaf index and page offset,
// reads one entry per level through a valid/ready request port with a
// single-beat read response, checks presence and permission at each level,
// and on success writes back the leaf entry when its tracking flags change.
// Assumes one outstanding memory request at a time and that a write is
// complete once accepted.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned OFF_W   = 10,
    parameter int unsigned LEAF_IW = 10,
    parameter int unsigned EW      = 32,
    parameter int unsigned ENT_LG  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         root_we,
    input  logic [EW-OFF_W+OFF_W-1:0]    root_wdata,
    output logic [EW-OFF_W+OFF_W-1:0]    root_q,
    input  logic                         req_valid,
    input  logic [VA_W-1:0]              req_vaddr,
    input  logic [1:0]                   req_acc,
    output logic                         busy,
    output logic                         done,
    output logic                         fault,
    output logic [1:0]                   fault_code,
    output logic [EW-OFF_W+OFF_W-1:0]    pa,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic                         mem_req_we,
    output logic [EW-OFF_W+OFF_W-1:0]    mem_req_addr,
    output logic [EW-1:0]                mem_req_wdata,
    input  logic                         mem_rsp_valid,
    input  logic [EW-1:0]                mem_rsp_data
);

    localparam int unsigned TOP_IW  = VA_W - OFF_W - LEAF_IW;
    localparam int unsigned FRAME_W = EW - OFF_W;
    localparam int unsigned PA_W    = FRAME_W + OFF_W;

    wstate_t          state;
    logic [VA_W-1:0]  va_q;
    logic [1:0]       acc_q;
    logic [PA_W-1:0]  leaf_tbl_q;
    logic [PA_W-1:0]  leaf_addr_q;
    logic [EW-1:0]    wb_data_q;
    logic [PA_W-1:0]  pa_q;
    logic             done_q;
    logic             fault_q;
    logic [1:0]       fcode_q;

    logic [TOP_IW-1:0]  top_idx;
    logic [LEAF_IW-1:0] leaf_idx;
    logic [OFF_W-1:0]   page_off;
    logic [PA_W-1:0]    top_addr;
    logic [PA_W-1:0]    leaf_addr;
    logic [FRAME_W-1:0] rsp_frame;

    logic               chk_pass;
    logic [1:0]         chk_code;
    logic [EW-1:0]      chk_updated;
    logic               chk_changed;

    // Field extraction from the latched virtual address and the response
    always_comb begin
        top_idx   = va_q[VA_W-1 -: TOP_IW];
        leaf_idx  = va_q[OFF_W +: LEAF_IW];
        page_off  = va_q[OFF_W-1:0];
        rsp_frame = mem_rsp_data[EW-1 -: FRAME_W];
    end

    assign busy = (state != WS_IDLE);

    ptw_root_reg #(
        .AW      (PA_W)
    ) u_root (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (root_we),
        .hold    (busy),
        .wdata   (root_wdata),
        .q       (root_q)
    );

    ptw_entry_addr #(
        .AW         (PA_W),
        .IDX_W      (TOP_IW),
        .ENT_LG     (ENT_LG)
    ) u_top_addr (
        .table_base (root_q),
        .index      (top_idx),
        .entry_addr (top_addr)
    );

    ptw_entry_addr #(
        .AW         (PA_W),
        .IDX_W      (LEAF_IW),
        .ENT_LG     (ENT_LG)
    ) u_leaf_addr (
        .table_base (leaf_tbl_q),
        .index      (leaf_idx),
        .entry_addr (leaf_addr)
    );

    ptw_entry_check #(
        .EW      (EW)
    ) u_check (
        .entry   (mem_rsp_data),
        .acc     (acc_q),
        .pass    (chk_pass),
        .code    (chk_code),
        .updated (chk_updated),
        .changed (chk_changed)
    );

    // Walk sequencer: accept, read top, read leaf, optional write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= WS_IDLE;
            va_q        <= '0;
            acc_q       <= '0;
            leaf_tbl_q  <= '0;
            leaf_addr_q <= '0;
            wb_data_q   <= '0;
            pa_q        <= '0;
            done_q      <= 1'b0;
            fault_q     <= 1'b0;
            fcode_q     <= FLT_NONE;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        acc_q   <= req_acc;
                        fcode_q <= FLT_NONE;
                        state   <= WS_TOP_REQ;
                    end
                end
                WS_TOP_REQ: begin
                    if (mem_req_ready) begin
                        state <= WS_TOP_RSP;
                    end
                end
                WS_TOP_RSP: begin
                    if (mem_rsp_valid) begin
                        if (!chk_pass) begin
                            fault_q <= 1'b1;
                            fcode_q <= chk_code;
                            state   <= WS_IDLE;
                        end else begin
                            leaf_tbl_q <= {rsp_frame, {OFF_W{1'b0}}};
                            state      <= WS_LEAF_REQ;
                        end
                    end
                end
                WS_LEAF_REQ: begin
                    if (mem_req_ready) begin
                        leaf_addr_q <= leaf_addr;
                        state       <= WS_LEAF_RSP;
                    end
                end
                WS_LEAF_RSP: begin
                    if (mem_rsp_valid) begin
                        if (!chk_pass) begin
                            fault_q <= 1'b1;
                            fcode_q <= chk_code;
                            state   <= WS_IDLE;
                        end else begin
                            pa_q <= {rsp_frame, page_off};
                            if (chk_changed) begin
                                wb_data_q <= chk_updated;
                                state     <= WS_WB_REQ;
                            end else begin
                                done_q <= 1'b1;
                                state  <= WS_IDLE;
                            end
                        end
                    end
                end
                WS_WB_REQ: begin
                    if (mem_req_ready) begin
                        done_q <= 1'b1;
                        state  <= WS_IDLE;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // Memory request drive: address chosen by the current step
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = top_addr;
        unique case (state)
            WS_TOP_REQ: begin
                mem_req_valid = 1'b1;
            end
            WS_LEAF_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = leaf_addr;
            end
            WS_WB_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = leaf_addr_q;
            end
            default: ;
        endcase
    end

    assign mem_req_wdata = wb_data_q;
    assign done          = done_q;
    assign fault         = fault_q;
    assign fault_code    = fcode_q;
    assign pa            = pa_q;

    // R10: a stalled request keeps its address and direction
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    // R3: memory is only used while a walk is running
    a_r3_mem_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R3: an accepted request makes the walker busy on the next cycle
    a_r3_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy |=> busy);

    // R11: the two completion pulses are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R11: completion pulses last a single cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R6: a fault always carries a nonzero code
    a_r6_code_present: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_code != FLT_NONE);

    // R9: a write-back always carries the accessed flag
    a_r9_wb_touched: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[E_TOUCHED]);

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [31:0] root_wdata = '0;
    logic [31:0] root_q;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_code;
    logic [31:0] pa;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    pt_walker dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .root_we       (root_we),
        .root_wdata    (root_wdata),
        .root_q        (root_q),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .busy          (busy),
        .done          (done),
        .fault         (fault),
        .fault_code    (fault_code),
        .pa            (pa),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Memory model state
    logic [31:0] mem [int unsigned];
    logic [15:0] lfsr = 16'hACE1;
    int unsigned rd_cnt = 0;
    int unsigned wr_cnt = 0;
    logic [31:0] rd_log [4];
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // Memory responder: random ready, one-cycle read latency
    always @(posedge clk) begin
        lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready <= (lfsr[1:0] != 2'b00);
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_addr <= mem_req_addr;
                wr_data <= mem_req_wdata;
                wr_cnt  <= wr_cnt + 1;
            end else begin
                mem_rsp_valid        <= 1'b1;
                mem_rsp_data         <= mem_rd(mem_req_addr);
                rd_log[rd_cnt % 4]   <= mem_req_addr;
                rd_cnt               <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit perm_ok(input logic [31:0] e, input logic [1:0] acc);
        case (acc)
            2'b00:   return e[1];
            2'b01:   return e[2];
            2'b10:   return e[3];
            default: return 1'b0;
        endcase
    endfunction

    // Run one walk and compare against a model built from the requirements
    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit poke);
        logic [31:0] base, top_a, top_e, leaf_a, leaf_e, new_e;
        logic [1:0]  e_code;
        int unsigned e_reads, e_writes, r0, w0, n;
        logic [31:0] e_pa;
        base   = root_q;
        top_a  = base + {18'b0, va[31:20], 2'b00};
        top_e  = mem_rd(top_a);
        leaf_a = {top_e[31:10], 10'b0} + {20'b0, va[19:10], 2'b00};
        leaf_e = mem_rd(leaf_a);
        new_e  = leaf_e | 32'h10 | ((acc == 2'b01) ? 32'h20 : 32'h0);
        e_pa   = {leaf_e[31:10], va[9:0]};
        e_writes = 0;
        if (!top_e[0]) begin
            e_code = 2'b01; e_reads = 1;
        end else if (!perm_ok(top_e, acc)) begin
            e_code = 2'b10; e_reads = 1;
        end else if (!leaf_e[0]) begin
            e_code = 2'b01; e_reads = 2;
        end else if (!perm_ok(leaf_e, acc)) begin
            e_code = 2'b10; e_reads = 2;
        end else begin
            e_code = 2'b00; e_reads = 2;
            e_writes = (new_e != leaf_e) ? 1 : 0;
        end
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 busy after accept", {31'b0, busy}, 32'd1);
        if (poke) begin
            root_we    = 1'b1;
            root_wdata = 32'hDEAD_0000;
            req_valid  = 1'b1;
            req_vaddr  = ~va;
            @(negedge clk);
            root_we   = 1'b0;
            req_valid = 1'b0;
        end
        n = 0;
        while (!(done || fault) && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (n >= 300) begin
            failures++;
            $display("FAIL R3 walk timeout actual=busy expected=completion");
        end
        chk("R3 busy low at completion", {31'b0, busy}, 32'd0);
        if (e_code == 2'b00) begin
            chk("R8 done", {30'b0, fault, done}, 32'd1);
            chk("R8 pa", pa, e_pa);
            chk("R9 write count", wr_cnt - w0, e_writes);
            if (e_writes == 1) begin
                chk("R9 write addr", wr_addr, leaf_a);
                chk("R9 write data", wr_data, new_e);
            end
        end else begin
            chk(e_code == 2'b01 ? "R6 absent fault" : "R7 denied fault",
                {28'b0, fault_code, fault, done}, {28'b0, e_code, 2'b10});
            chk("R6 R7 no write on fault", wr_cnt - w0, 32'd0);
        end
        chk("R3 R6 R7 read count", rd_cnt - r0, e_reads);
        if (rd_cnt - r0 >= 1) chk("R4 top address", rd_log[r0 % 4], top_a);
        if (e_reads == 2 && rd_cnt - r0 >= 2) chk("R5 leaf address", rd_log[(r0 + 1) % 4], leaf_a);
        @(negedge clk);
        chk("R11 single pulse", {30'b0, done, fault}, 32'd0);
        chk("R3 no second walk", {31'b0, busy}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] va, top_e, leaf_e, ta, la;
        logic [21:0] tf, lf;
        int unsigned i;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done fault", {30'b0, done, fault}, 32'd0);
        chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        chk("R1 root", root_q, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: load root while idle
        root_we = 1'b1;
        root_wdata = 32'h0001_0000;
        @(negedge clk);
        root_we = 1'b0;
        chk("R2 root load", root_q, 32'h0001_0000);

        // Sweep every flag combination and access kind
        i = 0;
        for (int tp = 0; tp < 16; tp++) begin
            for (int lp = 0; lp < 16; lp++) begin
                for (int ac = 0; ac < 4; ac++) begin
                    for (int rd = 0; rd < 4; rd++) begin
                        va = {12'((i * 37) % 4096), 10'((i * 53) % 1024), 10'(i % 1024)};
                        tf = 22'h200 + 22'(i % 64);
                        lf = 22'h3A5C0 ^ 22'(i);
                        top_e  = {tf, 6'b0, 4'(tp)};
                        leaf_e = {lf, 4'b0, 2'(rd), 4'(lp)};
                        ta = 32'h0001_0000 + {18'b0, va[31:20], 2'b00};
                        la = {tf, 10'b0} + {20'b0, va[19:10], 2'b00};
                        mem[ta] = top_e;
                        mem[la] = leaf_e;
                        walk(va, 2'(ac), 1'b0);
                        i++;
                    end
                end
            end
        end

        // R2 R3: root load and second request during a walk are ignored
        va = 32'h1234_5678;
        ta = 32'h0001_0000 + {18'b0, va[31:20], 2'b00};
        la = {22'h250, 10'b0} + {20'b0, va[19:10], 2'b00};
        mem[ta] = {22'h250, 10'h00F};
        mem[la] = {22'h1ABCD, 10'h03F};
        walk(va, 2'b01, 1'b1);
        chk("R2 root unchanged by busy load", root_q, 32'h0001_0000);

        // R2 R4: new root is used by the next walk
        @(negedge clk);
        root_we = 1'b1;
        root_wdata = 32'h0002_0400;
        @(negedge clk);
        root_we = 1'b0;
        chk("R2 root reload", root_q, 32'h0002_0400);
        va = 32'hFFF0_0123;
        ta = 32'h0002_0400 + {18'b0, va[31:20], 2'b00};
        la = {22'h251, 10'b0} + {20'b0, va[19:10], 2'b00};
        mem[ta] = {22'h251, 10'h003};
        mem[la] = {22'h00777, 10'h013};
        walk(va, 2'b00, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule